// File: doc/BRIEF.md
# Burst Beat Generator

This block sits on the manager side of an AHB-style bus and turns one burst request into the sequence of address-phase beats that the bus expects. A request is a start address, a beat size (log2 of bytes per beat), a burst kind and a one-cycle start strobe. From then on the block drives the beat address, the transfer type, the burst kind and the size for every beat. It moves to the next beat only when the bus signals ready, and it goes back to idle once the last beat has been taken.

Two address patterns are produced. Incrementing bursts step linearly by the beat size. Wrapping bursts step the same way, but they fold back inside a block whose length is the beat count times the beat size and which is aligned to that length, so a cache-line fill can start at the critical word and still stay inside its line. Fixed bursts of 4, 8 or 16 beats end by themselves. The open-ended incrementing kind runs until the owner of the block raises a stop request.

Top module: `burst_beat_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the transfer type, address, burst kind and size outputs are all zero (transfer type IDLE).
- R2: A start strobe seen while the block is idle makes the next cycle present the first beat with transfer type NONSEQ (2'b10), together with the requested address, size and burst kind. Burst kind codes: 3'b000 single, 3'b001 open-ended increment, 3'b011/3'b101/3'b111 increment by 4/8/16 beats, 3'b010/3'b100/3'b110 wrap over 4/8/16 beats.
- R3: Every beat after the first in a burst carries transfer type SEQ (2'b11). IDLE is 2'b00.
- R4: For incrementing kinds each new beat address is the previous one plus 2^size bytes, modulo the address width. The open-ended kind never folds back at any block boundary.
- R5: For wrapping kinds each new beat address is the previous one plus 2^size, kept inside the aligned block of (beat count × 2^size) bytes that holds the start address.
- R6: Single issues exactly one beat. The fixed kinds issue exactly 4, 8 or 16 beats.
- R7: An open-ended burst ends with the beat that is in the address phase when a stop request is seen. A stop seen during a stall is remembered until that beat is taken. A stop request has no effect on the other kinds or while idle.
- R8: While a beat is presented and ready is low, the address, transfer type, burst kind and size stay unchanged.
- R9: In the cycle after the last beat is taken the transfer type is IDLE, and it stays IDLE until a new start strobe.
- R10: A start strobe during a burst is ignored, including one that arrives in the cycle where the last beat is taken.
- R11: The burst kind and size stay constant across all beats of one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | Start a new burst (taken only when idle) |
| startAddr | input | ADDR_W | Address of the first beat |
| startSize | input | 3 | Beat size as log2 of bytes |
| startBurst | input | 3 | Burst kind code |
| stopReq | input | 1 | End an open-ended incrementing burst |
| ready | input | 1 | The bus takes the beat presented this cycle |
| addrOut | output | ADDR_W | Beat address |
| transOut | output | 2 | Transfer type (IDLE, NONSEQ, SEQ) |
| burstOut | output | 3 | Burst kind of the current beat |
| sizeOut | output | 3 | Beat size of the current beat |

## Verification
The bench goes after the wrap fold point for every wrapping length and beat size. A design with the block mask off by one bit would step out of the line, or wrap too early, and the address check flags it. It runs an open-ended burst across the top of the address space, where a design that treats it like a wrap would fold back instead of rolling over. It also raises stop during a stall and starts during the final accepted beat. A design that drops the remembered stop would run one beat long, and one that lets the late start through would skip the IDLE cycle. The beat count of every burst is compared against its kind, so off-by-one termination and stall slips show up as wrong totals.

// File: rtl/burst_beat_pkg.sv
package burst_beat_pkg;

  // Burst kind codes (a neighbour decodes these, so the values are fixed)
  localparam logic [2:0] BK_SINGLE = 3'b000;
  localparam logic [2:0] BK_INCR   = 3'b001;
  localparam logic [2:0] BK_WRAP4  = 3'b010;
  localparam logic [2:0] BK_INCR4  = 3'b011;
  localparam logic [2:0] BK_WRAP8  = 3'b100;
  localparam logic [2:0] BK_INCR8  = 3'b101;
  localparam logic [2:0] BK_WRAP16 = 3'b110;
  localparam logic [2:0] BK_INCR16 = 3'b111;

  // Transfer type codes
  localparam logic [1:0] TT_IDLE   = 2'b00;
  localparam logic [1:0] TT_NONSEQ = 2'b10;
  localparam logic [1:0] TT_SEQ    = 2'b11;

  localparam int MAX_BEATS = 16;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic stepBeat;
  } beatStrobe_t;

  // Beat total of a fixed kind; zero for the open-ended kind
  function automatic logic [CNT_W-1:0] fixedBeats(input logic [2:0] kind);
    case (kind)
      BK_SINGLE:           fixedBeats = CNT_W'(1);
      BK_WRAP4, BK_INCR4:  fixedBeats = CNT_W'(4);
      BK_WRAP8, BK_INCR8:  fixedBeats = CNT_W'(8);
      BK_WRAP16, BK_INCR16: fixedBeats = CNT_W'(16);
      default:             fixedBeats = '0;
    endcase
  endfunction

  function automatic logic isWrapKind(input logic [2:0] kind);
    isWrapKind = (kind == BK_WRAP4) || (kind == BK_WRAP8) || (kind == BK_WRAP16);
  endfunction

  // log2 of the beat count for wrapping kinds, zero otherwise
  function automatic logic [2:0] wrapLog2(input logic [2:0] kind);
    case (kind)
      BK_WRAP4:  wrapLog2 = 3'd2;
      BK_WRAP8:  wrapLog2 = 3'd3;
      BK_WRAP16: wrapLog2 = 3'd4;
      default:   wrapLog2 = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/beat_addr_path.sv
module beat_addr_path
  import burst_beat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  beatStrobe_t       strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        startSize,
  input  logic [2:0]        startBurst,
  output logic [ADDR_W-1:0] addrQ,
  output logic [2:0]        burstQ,
  output logic [2:0]        sizeQ
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] blockMask;
  logic [ADDR_W-1:0] linearNext;
  logic [ADDR_W-1:0] foldedNext;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    stepBytes  = ONE << sizeQ;
    blockMask  = (stepBytes << wrapLog2(burstQ)) - ONE;
    linearNext = addrQ + stepBytes;
    foldedNext = (addrQ & ~blockMask) | (linearNext & blockMask);
    nextAddr   = isWrapKind(burstQ) ? foldedNext : linearNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      burstQ <= BK_SINGLE;
      sizeQ  <= '0;
    end else if (strobe.loadStart) begin
      addrQ  <= startAddr;
      burstQ <= startBurst;
      sizeQ  <= startSize;
    end else if (strobe.stepBeat) begin
      addrQ  <= nextAddr;
    end
  end

  // R5: a wrapping step never leaves the aligned block
  p_wrap_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepBeat && isWrapKind(burstQ)) |=>
      ((addrQ & ~blockMask) == $past(addrQ & ~blockMask)))
    else $error("wrapping beat left its block");

  // R4: an incrementing step moves by exactly the beat size
  p_incr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepBeat && !isWrapKind(burstQ)) |=>
      (addrQ == $past(addrQ) + $past(stepBytes)))
    else $error("incrementing beat has wrong stride");

endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import burst_beat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        stopReq,
  input  logic        ready,
  input  logic [2:0]  burstQ,
  output beatStrobe_t strobe,
  output logic [1:0]  transQ
);

  logic [CNT_W-1:0] beatCntQ;
  logic             stopPendQ;
  logic             inBurst;
  logic             accept;
  logic             openKind;
  logic             stopSeen;
  logic             lastBeat;

  always_comb begin
    inBurst  = (transQ != TT_IDLE);
    accept   = inBurst && ready;
    openKind = (burstQ == BK_INCR);
    stopSeen = openKind && (stopPendQ || stopReq);
    lastBeat = openKind ? stopSeen
                        : ((beatCntQ + CNT_W'(1)) == fixedBeats(burstQ));
    strobe.loadStart = !inBurst && startStb;
    strobe.stepBeat  = accept && !lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      transQ    <= TT_IDLE;
      beatCntQ  <= '0;
      stopPendQ <= 1'b0;
    end else if (strobe.loadStart) begin
      transQ    <= TT_NONSEQ;
      beatCntQ  <= '0;
      stopPendQ <= 1'b0;
    end else if (accept) begin
      if (lastBeat) begin
        transQ    <= TT_IDLE;
        beatCntQ  <= '0;
        stopPendQ <= 1'b0;
      end else begin
        transQ <= TT_SEQ;
        if (!openKind) beatCntQ <= beatCntQ + CNT_W'(1);
      end
    end else if (inBurst && openKind && stopReq) begin
      stopPendQ <= 1'b1;
    end
  end

  // R2: a start taken while idle yields a NONSEQ beat
  p_start_nonseq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!inBurst && startStb) |=> (transQ == TT_NONSEQ))
    else $error("start did not produce NONSEQ");

  // R3: SEQ only follows a beat of the same burst
  p_seq_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    (transQ == TT_SEQ) |-> ($past(transQ) != TT_IDLE))
    else $error("SEQ after IDLE");

  // R6: the beat counter stays below the kind's total
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inBurst && !openKind) |-> (beatCntQ < fixedBeats(burstQ)))
    else $error("beat count overran");

  // R7: a stop with ready ends the open-ended burst
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inBurst && openKind && stopReq && ready) |=> (transQ == TT_IDLE))
    else $error("stop did not end the burst");

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
  import burst_beat_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        startSize,
  input  logic [2:0]        startBurst,
  input  logic              stopReq,
  input  logic              ready,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        transOut,
  output logic [2:0]        burstOut,
  output logic [2:0]        sizeOut
);

  beatStrobe_t strobe;
  logic [2:0]  burstQ;

  beat_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .stopReq  (stopReq),
    .ready    (ready),
    .burstQ   (burstQ),
    .strobe   (strobe),
    .transQ   (transOut)
  );

  beat_addr_path #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startAddr  (startAddr),
    .startSize  (startSize),
    .startBurst (startBurst),
    .addrQ      (addrOut),
    .burstQ     (burstQ),
    .sizeQ      (sizeOut)
  );

  assign burstOut = burstQ;

  // R8: a stalled beat holds every address-phase output
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (transOut != TT_IDLE && !ready) |=>
      ($stable(addrOut) && $stable(transOut) && $stable(burstOut) && $stable(sizeOut)))
    else $error("address phase changed during stall");

  // R11: kind and size are constant within a burst
  p_kind_const_r11: assert property (@(posedge clk) disable iff (!rstN)
    (transOut == TT_SEQ) |-> (burstOut == $past(burstOut) && sizeOut == $past(sizeOut)))
    else $error("burst kind or size changed mid-burst");

endmodule

// File: tb/burst_beat_gen_tb.sv
module burst_beat_gen_tb;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startStb = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [2:0]        startSize = '0;
  logic [2:0]        startBurst = '0;
  logic              stopReq = 1'b0;
  logic              ready = 1'b0;
  logic [ADDR_W-1:0] addrOut;
  logic [1:0]        transOut;
  logic [2:0]        burstOut;
  logic [2:0]        sizeOut;

  always #2 clk = ~clk;

  burst_beat_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startAddr(startAddr),
    .startSize(startSize), .startBurst(startBurst), .stopReq(stopReq),
    .ready(ready), .addrOut(addrOut), .transOut(transOut),
    .burstOut(burstOut), .sizeOut(sizeOut)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  // reference state
  bit              mActive = 0;
  logic [31:0]     mAddr = '0;
  logic [1:0]      mTrans = 2'b00;
  logic [2:0]      mBurst = '0;
  logic [2:0]      mSize = '0;
  int              mCnt = 0;
  bit              mStopPend = 0;
  int              dutBeats = 0;
  int              expBeats = 0;
  bit              pendCount = 0;
  string           countTag = "R6";
  string           lastTag = "";

  function automatic int beatsOf(input logic [2:0] b);
    case (b)
      3'b000: return 1;
      3'b010, 3'b011: return 4;
      3'b100, 3'b101: return 8;
      3'b110, 3'b111: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic bit wrapsKind(input logic [2:0] b);
    return (b == 3'b010) || (b == 3'b100) || (b == 3'b110);
  endfunction

  function automatic logic [31:0] nextOf(input logic [31:0] a, input logic [2:0] s,
                                         input logic [2:0] b);
    longint unsigned bytes = longint'(1) << s;
    longint unsigned block;
    longint unsigned base;
    if (!wrapsKind(b)) return 32'((longint'(a) + bytes) % (longint'(1) << 32));
    block = bytes * longint'(beatsOf(b));
    base  = longint'(a) - (longint'(a) % block);
    return 32'(base + ((longint'(a) - base + bytes) % block));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareOutputs();
    string tt;
    string ta;
    if (pendCount) begin
      check(dutBeats == expBeats, countTag, "beat count", 32'(dutBeats), 32'(expBeats));
      pendCount = 0;
      dutBeats  = 0;
    end
    tt = (lastTag != "") ? lastTag :
         (mTrans == 2'b00) ? "R9" : (mTrans == 2'b10) ? "R2" : "R3";
    check(transOut == mTrans, tt, "transfer type", 32'(transOut), 32'(mTrans));
    if (mActive) begin
      ta = (lastTag != "") ? lastTag : (mTrans == 2'b10) ? "R2" :
           wrapsKind(mBurst) ? "R5" : "R4";
      check(addrOut == mAddr, ta, "address", addrOut, mAddr);
      check(burstOut == mBurst && sizeOut == mSize, (lastTag != "") ? lastTag : "R11",
            "kind/size", {26'd0, burstOut, sizeOut}, {26'd0, mBurst, mSize});
    end
  endtask

  task automatic modelStep(input bit st, input logic [31:0] sa, input logic [2:0] ss,
                           input logic [2:0] sb, input bit rdy, input bit stp);
    bit openK;
    bit stopNow;
    bit last;
    if (!mActive) begin
      if (st) begin
        mActive = 1; mAddr = sa; mSize = ss; mBurst = sb;
        mTrans = 2'b10; mCnt = 0; mStopPend = 0; dutBeats = 0;
      end else mTrans = 2'b00;
    end else begin
      openK   = (mBurst == 3'b001);
      stopNow = openK && (mStopPend || stp);
      if (rdy) begin
        last = openK ? stopNow : (mCnt + 1 == beatsOf(mBurst));
        if (last) begin
          mActive = 0; mTrans = 2'b00; mStopPend = 0;
          expBeats = mCnt + 1; pendCount = 1; countTag = openK ? "R7" : "R6";
        end else begin
          mAddr = nextOf(mAddr, mSize, mBurst); mTrans = 2'b11; mCnt++;
        end
      end else if (openK && stp) mStopPend = 1;
    end
  endtask

  // one cycle: check what the last cycle produced, drive, predict, advance
  task automatic tick(input bit st, input logic [31:0] sa, input logic [2:0] ss,
                      input logic [2:0] sb, input bit rdy, input bit stp, input string tag);
    compareOutputs();
    lastTag = tag;
    startStb = st; startAddr = sa; startSize = ss; startBurst = sb;
    ready = rdy; stopReq = stp;
    if (transOut != 2'b00 && rdy) dutBeats++;
    modelStep(st, sa, ss, sb, rdy, stp);
    @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] a, input logic [2:0] s, input logic [2:0] b,
                        input string tag);
    tick(1, a, s, b, 0, 0, tag);
  endtask

  task automatic drain(input int rdyPct, input int stopAt, input string tag);
    for (int g = 0; g < 400 && mActive; g++) begin
      bit r = ($urandom_range(99) < rdyPct);
      tick(0, '0, '0, '0, r, (stopAt >= 0 && mCnt >= stopAt), tag);
    end
    tick(0, '0, '0, '0, 1, 0, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check(transOut == 2'b00 && addrOut == 0 && burstOut == 0 && sizeOut == 0,
          "R1", "reset outputs", addrOut | 32'(transOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(transOut == 2'b00 && addrOut == 0, "R1", "after reset", 32'(transOut), 32'd0);

    // R2/R4/R6: incrementing 4 beats of words from 0x100
    launch(32'h100, 3'd2, 3'b011, "R2");
    drain(100, -1, "R4");
    // R5: 4-beat wrap of words from 0x38 -> 38,3C,30,34
    launch(32'h38, 3'd2, 3'b010, "R2");
    drain(100, -1, "R5");
    // R5: 8-beat wrap of halfwords from 0x1E with stalls
    launch(32'h1E, 3'd1, 3'b100, "R2");
    drain(60, -1, "R5");
    // R5: 16-beat wrap of bytes from 0x4B
    launch(32'h4B, 3'd0, 3'b110, "R2");
    drain(100, -1, "R5");
    // R6: single beat
    launch(32'h2000, 3'd2, 3'b000, "R2");
    drain(100, -1, "R6");
    // R4: open-ended burst crossing the top of the address space, no fold
    launch(32'hFFFF_FFF8, 3'd2, 3'b001, "R2");
    drain(100, 4, "R4");

    // R7: stop raised during a stall is remembered
    launch(32'h400, 3'd2, 3'b001, "R2");
    tick(0, '0, '0, '0, 1, 0, "R7");
    tick(0, '0, '0, '0, 1, 0, "R7");
    tick(0, '0, '0, '0, 0, 1, "R7");   // stop while stalled
    tick(0, '0, '0, '0, 0, 0, "R7");
    tick(0, '0, '0, '0, 1, 0, "R7");   // beat taken: ends here
    tick(0, '0, '0, '0, 1, 0, "R7");
    check(transOut == 2'b00, "R7", "stop remembered", 32'(transOut), 32'd0);

    // R7: stop has no effect on a fixed 8-beat burst
    launch(32'h800, 3'd3, 3'b101, "R2");
    drain(100, 0, "R7");

    // R8: long stall holds the beat
    launch(32'h600, 3'd2, 3'b111, "R2");
    for (int i = 0; i < 6; i++) tick(0, '0, '0, '0, 0, 0, "R8");
    drain(70, -1, "R8");

    // R10: start during a burst and in the last-beat cycle is ignored
    launch(32'hA00, 3'd2, 3'b011, "R2");
    tick(1, 32'h5555_0000, 3'd0, 3'b111, 1, 0, "R10");
    tick(1, 32'h5555_0000, 3'd0, 3'b111, 1, 0, "R10");
    tick(0, '0, '0, '0, 1, 0, "R10");
    tick(1, 32'h7777_0000, 3'd1, 3'b010, 1, 0, "R10"); // last beat taken here
    tick(0, '0, '0, '0, 1, 0, "R9");
    check(transOut == 2'b00, "R10", "late start ignored", 32'(transOut), 32'd0);
    tick(0, '0, '0, '0, 1, 0, "R9");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [2:0]  s = 3'($urandom_range(3));
      logic [31:0] a = $urandom() & ~((32'd1 << s) - 32'd1);
      tick($urandom_range(99) < 30, a, s, 3'($urandom_range(7)),
           $urandom_range(99) < 75, $urandom_range(99) < 10, "");
    end
    drain(100, 0, "");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule